// File: doc/BRIEF.md
# Receiver-Referenced VPW Symbol Timer

This block drives the transmit line of a variable-pulse-width serial bus node, one symbol at a time. Symbol length is not counted from the node's own transmit edge. The count starts at the first timebase tick on which the filtered receive line shows the level the symbol asked for. The echo path adds delay through the external transceiver and through the input filter. The count therefore covers the nominal symbol length minus both delays, and the bus still sees nominal timing. If another node drove the bus to that level first, the count starts from that node's edge. In this way the node locks onto whichever transmitter began first.

An encoder above this block requests one symbol at a time by pulsing `sym_start` with a length code and a level. The block strobes `sym_done` when the symbol's time is up, releasing the line in the same cycle, and the encoder may then request the next symbol. Two conditions are sticky and block all further transmission until the encoder pulses `frame_end`. The first is lost arbitration: the bus shows the active level while this node is timing a passive symbol. The second is a transmitter fault: no echo of the requested level arrives within a bounded number of ticks.

Top module: `vpw_sym_timer`

## Requirements
- R1: After reset, `tx_out`, `sym_done`, `arb_lost` and `tx_fault` are all 0.
- R2: A `sym_start` pulse accepted while idle, with neither sticky flag set, makes `tx_out` equal to `sym_level` from the next clock on (1 = active, 0 = passive).
- R3: `sym_done` pulses at the N-th `tick` after the first tick on which `rx_bus` equals the symbol's level. N = nominal − `xcvr_dly` − 8. The nominal length comes from `sym_code`: 0 = 64, 1 = 128, 2 = 200, 3 = 200 ticks. `xcvr_dly` is captured at the start. Clock cycles between ticks have no effect, however irregular the tick spacing.
- R4: If `rx_bus` already shows the requested level on the first tick after the start, timing begins on that tick. This lets the node resynchronize to an earlier transmitter.
- R5: `tx_out` is 0 in the cycle `sym_done` is high, and `sym_done` lasts one clock.
- R6: During the timing of a passive symbol, a tick that sees `rx_bus` = 1 before the final tick sets `arb_lost`. It also drops `tx_out` to 0 and ends the symbol without `sym_done`.
- R7: If `rx_bus` = 1 appears on the final tick of a passive symbol, the symbol completes with `sym_done` and `arb_lost` stays 0.
- R8: While `arb_lost` or `tx_fault` is set, `sym_start` is ignored: `tx_out` stays 0 and `sym_done` stays 0.
- R9: If no tick shows the requested level within 48 ticks after the start, `tx_fault` is set on the 48th tick. `tx_out` drops to 0 and no `sym_done` is given.
- R10: A `frame_end` pulse clears `arb_lost` and `tx_fault` on the next clock, and takes priority over a flag being set in the same cycle.
- R11: A `sym_start` pulse while a symbol is in flight changes neither `tx_out` nor the symbol's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe, one per microsecond |
| rx_bus | input | 1 | Filtered receive level, 1 = active |
| sym_start | input | 1 | Request to transmit one symbol |
| sym_code | input | 2 | Symbol length code |
| sym_level | input | 1 | Level to drive for the symbol |
| xcvr_dly | input | 5 | Transceiver delay in ticks |
| frame_end | input | 1 | Clears the sticky flags |
| tx_out | output | 1 | Transmit line, 1 = active |
| sym_done | output | 1 | End-of-symbol strobe |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| tx_fault | output | 1 | Sticky missing-echo flag |

## Verification
Completion of a passive symbol and detection of a foreign active level can fall on the same tick. The arbitration test places the competitor's edge relative to the echo tick that the bench records itself. Placed exactly N ticks after the echo, the competitor edge lands on the final tick, and the bench expects `sym_done` with `arb_lost` clear. Placed a few ticks earlier, it expects `arb_lost` with no strobe and a released line.

// File: rtl/vpw_timer_pkg.sv
package vpw_timer_pkg;

  typedef enum logic [1:0] {
    SYM_SHORT = 2'd0,
    SYM_LONG  = 2'd1,
    SYM_SOF   = 2'd2,
    SYM_EOD   = 2'd3
  } vpw_sym_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ECHO = 2'd1,
    PH_SPAN = 2'd2
  } vpw_phase_e;

  // Ticks left to count once the receiver sees the level.
  function automatic int unsigned span_ticks(input int unsigned nominal,
                                             input int unsigned xcvr,
                                             input int unsigned filt);
    return nominal - xcvr - filt;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vpw_span_sel.sv
module vpw_span_sel
  import vpw_timer_pkg::*;
#(
  parameter int unsigned DLY_W    = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned FILT_US  = 8,
  parameter int unsigned SHORT_US = 64,
  parameter int unsigned LONG_US  = 128,
  parameter int unsigned SOF_US   = 200,
  parameter int unsigned EOD_US   = 200
) (
  input  vpw_sym_e           code,
  input  logic [DLY_W-1:0]   dly,
  output logic [CNT_W-1:0]   span
);

  int unsigned nominal;

  always_comb begin
    case (code)
      SYM_SHORT: nominal = SHORT_US;
      SYM_LONG:  nominal = LONG_US;
      SYM_SOF:   nominal = SOF_US;
      default:   nominal = EOD_US;
    endcase
    span = CNT_W'(span_ticks(nominal, int'(dly), FILT_US));
  end

  always_comb begin
    assert_span_positive_R3: assert (span_ticks(nominal, int'(dly), FILT_US) > 1 || $isunknown(code))
      else $error("span shorter than two ticks");
  end

endmodule

// File: rtl/vpw_echo_watch.sv
module vpw_echo_watch #(
  parameter int unsigned ECHO_TMO = 48,
  parameter int unsigned TMO_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic rx,
  input  logic lvl,
  output logic echo_hit,
  output logic timeout_hit
);

  logic [TMO_W-1:0] wcnt;
  logic             level_seen;

  assign level_seen  = (rx == lvl);
  assign echo_hit    = active & tick & level_seen;
  assign timeout_hit = active & tick & ~level_seen & (wcnt == TMO_W'(ECHO_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wcnt <= '0;
    else if (!active)        wcnt <= '0;
    else if (tick && !level_seen) wcnt <= wcnt + 1'b1;
  end

  assert_wait_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (wcnt < TMO_W'(ECHO_TMO)))
    else $error("echo wait counter ran past its limit");

  assert_wait_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(wcnt))
    else $error("echo wait counter moved without a tick");

endmodule

// File: rtl/vpw_span_timer.sv
module vpw_span_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] span,
  output logic             done_hit
);

  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = (cnt == CNT_W'(1));
  assign done_hit  = run & tick & last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (load)                    cnt <= span;
    else if (run && tick && !last_tick) cnt <= cnt - 1'b1;
  end

  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0))
    else $error("span counter empty while timing");

  assert_count_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt))
    else $error("span counter moved between ticks");

endmodule

// File: rtl/vpw_hold_flags.sv
module vpw_hold_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic lvl,
  input  logic rx,
  input  logic done_hit,
  input  logic timeout_hit,
  input  logic frame_end,
  output logic loss_hit,
  output logic arb_lost,
  output logic tx_fault
);

  // A foreign active level during our passive span; completion wins.
  assign loss_hit = run & tick & ~lvl & rx & ~done_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost <= 1'b0;
      tx_fault <= 1'b0;
    end else if (frame_end) begin
      arb_lost <= 1'b0;
      tx_fault <= 1'b0;
    end else begin
      if (loss_hit)    arb_lost <= 1'b1;
      if (timeout_hit) tx_fault <= 1'b1;
    end
  end

  assert_flags_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!arb_lost && !tx_fault))
    else $error("frame end did not clear the flags");

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !frame_end) |=> arb_lost)
    else $error("arbitration flag dropped on its own");

endmodule

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer
  import vpw_timer_pkg::*;
#(
  parameter int unsigned DLY_W    = 5,
  parameter int unsigned FILT_US  = 8,
  parameter int unsigned SHORT_US = 64,
  parameter int unsigned LONG_US  = 128,
  parameter int unsigned SOF_US   = 200,
  parameter int unsigned EOD_US   = 200,
  parameter int unsigned ECHO_TMO = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_bus,
  input  logic       sym_start,
  input  logic [1:0] sym_code,
  input  logic       sym_level,
  input  logic [4:0] xcvr_dly,
  input  logic       frame_end,
  output logic       tx_out,
  output logic       sym_done,
  output logic       arb_lost,
  output logic       tx_fault
);

  localparam int unsigned MAX_US = max2(max2(SHORT_US, LONG_US), max2(SOF_US, EOD_US));
  localparam int unsigned CNT_W  = $clog2(MAX_US + 1);
  localparam int unsigned TMO_W  = $clog2(ECHO_TMO + 1);

  vpw_phase_e        phase;
  vpw_sym_e          code_q;
  logic [DLY_W-1:0]  dly_q;
  logic              lvl_q;
  logic              drive_q;
  logic              done_q;

  logic              hold;
  logic              start_ok;
  logic              in_echo;
  logic              in_span;
  logic              echo_hit;
  logic              timeout_hit;
  logic              done_hit;
  logic              loss_hit;
  logic [CNT_W-1:0]  span;

  assign hold     = arb_lost | tx_fault;
  assign start_ok = sym_start & (phase == PH_IDLE) & ~hold;
  assign in_echo  = (phase == PH_ECHO);
  assign in_span  = (phase == PH_SPAN);

  vpw_span_sel #(
    .DLY_W(DLY_W), .CNT_W(CNT_W), .FILT_US(FILT_US),
    .SHORT_US(SHORT_US), .LONG_US(LONG_US), .SOF_US(SOF_US), .EOD_US(EOD_US)
  ) i_span_sel (
    .code (code_q),
    .dly  (dly_q),
    .span (span)
  );

  vpw_echo_watch #(.ECHO_TMO(ECHO_TMO), .TMO_W(TMO_W)) i_echo_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (in_echo),
    .tick        (tick),
    .rx          (rx_bus),
    .lvl         (lvl_q),
    .echo_hit    (echo_hit),
    .timeout_hit (timeout_hit)
  );

  vpw_span_timer #(.CNT_W(CNT_W)) i_span_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (echo_hit),
    .run      (in_span),
    .span     (span),
    .done_hit (done_hit)
  );

  vpw_hold_flags i_hold_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (in_span),
    .tick        (tick),
    .lvl         (lvl_q),
    .rx          (rx_bus),
    .done_hit    (done_hit),
    .timeout_hit (timeout_hit),
    .frame_end   (frame_end),
    .loss_hit    (loss_hit),
    .arb_lost    (arb_lost),
    .tx_fault    (tx_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      code_q  <= SYM_SHORT;
      dly_q   <= '0;
      lvl_q   <= 1'b0;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start_ok) begin
            phase   <= PH_ECHO;
            code_q  <= vpw_sym_e'(sym_code);
            dly_q   <= xcvr_dly;
            lvl_q   <= sym_level;
            drive_q <= sym_level;
          end
        end
        PH_ECHO: begin
          if (timeout_hit) begin
            phase   <= PH_IDLE;
            drive_q <= 1'b0;
          end else if (echo_hit) begin
            phase   <= PH_SPAN;
          end
        end
        PH_SPAN: begin
          if (done_hit) begin
            phase   <= PH_IDLE;
            drive_q <= 1'b0;
            done_q  <= 1'b1;
          end else if (loss_hit) begin
            phase   <= PH_IDLE;
            drive_q <= 1'b0;
          end
        end
        default: begin
          phase   <= PH_IDLE;
          drive_q <= 1'b0;
        end
      endcase
    end
  end

  assign tx_out   = drive_q;
  assign sym_done = done_q;

  assert_start_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (tx_out == $past(sym_level)))
    else $error("accepted start did not drive the level");

  assert_release_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_done |-> !tx_out)
    else $error("line still driven at end of symbol");

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_done |=> !sym_done)
    else $error("end strobe longer than one clock");

  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!tx_out && !sym_done))
    else $error("line active while a sticky flag is set");

  assert_loss_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !sym_done)
    else $error("arbitration loss together with completion");

  assert_fault_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fault) |-> (!tx_out && !sym_done))
    else $error("fault raised with line still driven");

  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !timeout_hit && !done_hit && !loss_hit) |=> $stable(tx_out))
    else $error("line changed during a symbol");

endmodule

// File: tb/test_vpw_sym_timer.sv
module test_vpw_sym_timer;

  localparam int TMO = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rx_bus = 1'b0;
  logic sym_start = 1'b0;
  logic [1:0] sym_code = 2'd0;
  logic sym_level = 1'b0;
  logic [4:0] xcvr_dly = 5'd0;
  logic frame_end = 1'b0;
  logic tx_out, sym_done, arb_lost, tx_fault;

  vpw_sym_timer i_vpw_sym_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_bus(rx_bus),
    .sym_start(sym_start), .sym_code(sym_code), .sym_level(sym_level),
    .xcvr_dly(xcvr_dly), .frame_end(frame_end),
    .tx_out(tx_out), .sym_done(sym_done), .arb_lost(arb_lost), .tx_fault(tx_fault)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int dly = 14;
  bit echo_en = 1'b1;
  bit comp = 1'b0;
  int comp_at = 32'h7fff_ffff;
  int gap = 2;
  logic [63:0] hist = '0;
  bit finished = 1'b0;

  // recorder state (updated at posedge from bench-driven inputs only)
  int tkn = 0;
  bit waiting = 1'b0;
  logic wlvl = 1'b0;
  int echo_tk = 0;
  int start_tk = 0;
  bit ign_start = 1'b0;

  function automatic int nominal(input int code);
    case (code)
      0: return 64;
      1: return 128;
      default: return 200;
    endcase
  endfunction

  function automatic int exp_span(input int code, input int d);
    return nominal(code) - d - 8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Timebase, bus model and watchdog.
  always @(negedge clk) begin
    cyc++;
    if (gap == 0) begin
      tick = 1'b1;
      gap = 1 + int'($urandom % 4);
      hist = {hist[62:0], tx_out};
    end else begin
      tick = 1'b0;
      gap--;
    end
    rx_bus = (echo_en && hist[dly + 7]) || comp || (tkn + 1 >= comp_at);
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  always @(posedge clk) begin
    if (tick) tkn <= tkn + 1;
    if (sym_start && !ign_start) begin
      waiting  <= 1'b1;
      wlvl     <= sym_level;
      start_tk <= tick ? tkn + 1 : tkn;
    end else if (waiting && tick && rx_bus == wlvl) begin
      echo_tk <= tkn + 1;
      waiting <= 1'b0;
    end
  end

  // outcome: 0 done, 1 arbitration lost, 2 fault, 3 nothing
  task automatic send(input int code, input bit lvl, input int comp_off,
                      input int mid, output int outcome);
    int n;
    n = exp_span(code, dly);
    @(negedge clk);
    sym_code = code[1:0]; sym_level = lvl; xcvr_dly = dly[4:0]; sym_start = 1'b1;
    @(negedge clk);
    sym_start = 1'b0;
    chk(tx_out == lvl, "R2 level driven", int'(tx_out), int'(lvl));
    if (comp_off >= 0 || mid > 0) begin
      for (int i = 0; i < 2000 && waiting; i++) @(negedge clk);
      if (comp_off >= 0) comp_at = echo_tk + comp_off;
      if (mid > 0) begin
        repeat (mid) @(negedge clk);
        ign_start = 1'b1; sym_code = 2'd0; sym_level = ~lvl; sym_start = 1'b1;
        @(negedge clk);
        sym_start = 1'b0; sym_level = lvl; sym_code = code[1:0];
        @(negedge clk);
        ign_start = 1'b0;
        chk(tx_out == lvl, "R11 busy start ignored", int'(tx_out), int'(lvl));
      end
    end
    outcome = 3;
    for (int i = 0; i < 4000; i++) begin
      if (sym_done) begin outcome = 0; break; end
      if (arb_lost) begin outcome = 1; break; end
      if (tx_fault) begin outcome = 2; break; end
      @(negedge clk);
    end
    if (outcome == 0) begin
      chk(tkn - echo_tk == n, "R3 span after echo", tkn - echo_tk, n);
      chk(tx_out == 1'b0, "R5 released on done", int'(tx_out), 0);
      @(negedge clk);
      chk(sym_done == 1'b0, "R5 single strobe", int'(sym_done), 0);
    end
  endtask

  task automatic wait_ticks(input int n);
    int seen;
    seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (tick) seen++;
    end
  endtask

  task automatic close_frame();
    comp = 1'b0;
    comp_at = 32'h7fff_ffff;
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    wait_ticks(80);
  endtask

  task automatic try_ignored(input string req);
    int bad;
    bad = 0;
    @(negedge clk);
    sym_code = 2'd2; sym_level = 1'b1; ign_start = 1'b1; sym_start = 1'b1;
    @(negedge clk);
    sym_start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (tx_out || sym_done) bad++;
      @(negedge clk);
    end
    ign_start = 1'b0;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    int oc;
    int n;
    void'($urandom(32'd2024));
    repeat (8) @(negedge clk);
    chk(tx_out == 0 && sym_done == 0, "R1 reset outputs", int'({tx_out, sym_done}), 0);
    chk(arb_lost == 0 && tx_fault == 0, "R1 reset flags", int'({arb_lost, tx_fault}), 0);
    rst_n = 1'b1;
    wait_ticks(4);

    // Directed frame with a 14-tick transceiver delay.
    dly = 14;
    send(2, 1'b1, -1, 0, oc); chk(oc == 0, "R3 SOF completes", oc, 0);
    send(0, 1'b0, -1, 0, oc); chk(oc == 0, "R3 short passive", oc, 0);
    send(1, 1'b1, -1, 0, oc); chk(oc == 0, "R3 long active", oc, 0);
    send(3, 1'b0, -1, 0, oc); chk(oc == 0, "R3 EOD passive", oc, 0);
    close_frame();

    // R11: start pulse in the middle of a symbol.
    dly = 10;
    send(2, 1'b1, -1, 30, oc); chk(oc == 0, "R11 symbol still completes", oc, 0);
    close_frame();

    // R4: competitor already holds the bus active.
    dly = 20;
    comp = 1'b1;
    wait_ticks(3);
    send(2, 1'b1, -1, 0, oc);
    chk(oc == 0, "R4 resync completes", oc, 0);
    chk(echo_tk == start_tk + 1, "R4 timing from first tick", echo_tk, start_tk + 1);
    close_frame();

    // R6 then R8 and R10.
    dly = 14;
    send(2, 1'b1, -1, 0, oc);
    n = exp_span(0, dly);
    send(0, 1'b0, n - 6, 0, oc);
    chk(oc == 1, "R6 loss detected", oc, 1);
    chk(tx_out == 0, "R6 line released", int'(tx_out), 0);
    chk(sym_done == 0, "R6 no strobe", int'(sym_done), 0);
    comp_at = 32'h7fff_ffff;
    try_ignored("R8 start ignored after loss");
    chk(arb_lost == 1, "R8 loss flag sticky", int'(arb_lost), 1);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk(arb_lost == 0, "R10 loss cleared", int'(arb_lost), 0);
    close_frame();

    // R7: competitor edge on the final tick of a passive symbol.
    dly = 9;
    send(2, 1'b1, -1, 0, oc);
    n = exp_span(0, dly);
    send(0, 1'b0, n, 0, oc);
    chk(oc == 0, "R7 completion wins", oc, 0);
    chk(arb_lost == 0, "R7 no loss flag", int'(arb_lost), 0);
    close_frame();

    // R9: echo missing.
    dly = 14;
    echo_en = 1'b0;
    send(2, 1'b1, -1, 0, oc);
    chk(oc == 2, "R9 fault raised", oc, 2);
    chk(tkn == start_tk + TMO, "R9 fault tick", tkn, start_tk + TMO);
    chk(tx_out == 0, "R9 line released", int'(tx_out), 0);
    try_ignored("R8 start ignored after fault");
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk(tx_fault == 0, "R10 fault cleared", int'(tx_fault), 0);
    echo_en = 1'b1;
    close_frame();

    // Random frames with random delays and tick spacing.
    for (int f = 0; f < 10; f++) begin
      int nd;
      bit lv;
      dly = int'($urandom % 32);
      send(2, 1'b1, -1, 0, oc); chk(oc == 0, "R3 random SOF", oc, 0);
      nd = 2 * (1 + int'($urandom % 3));
      lv = 1'b0;
      for (int k = 0; k < nd; k++) begin
        send(int'($urandom % 2), lv, -1, 0, oc);
        chk(oc == 0, "R3 random data symbol", oc, 0);
        lv = ~lv;
      end
      send(3, 1'b0, -1, 0, oc); chk(oc == 0, "R3 random EOD", oc, 0);
      close_frame();
    end

    finished = 1'b1;
    summary();
  end

endmodule